// File: doc/BRIEF.md
# Bit-Serial Feistel Round Engine

This block runs a 128-bit Simon-style Feistel cipher state through a chosen number of rounds. It produces one state bit per clock. Each round takes one 64-bit round key, which arrives one bit per cycle, least significant bit first. The key schedule is outside the block, so whatever drives the key input supplies every round key. Masking is also outside the block.

Each round computes a new left word: the right word, XOR the left word rotated left by two, XOR the AND of the left word rotated left by one and by eight, XOR the round key. The old left word becomes the new right word.

The right word is kept in a 64-bit shift chain. The left word is kept in a 56-bit shift chain plus two 8-bit windows. In each round one window is "old". It holds the eight most recent old left bits, and these supply the three rotated taps. The other window is "new" and collects freshly computed bits. After its first eight bits, it starts feeding the 56-bit chain. The two windows trade roles at every round boundary.

A user loads a block with `start` and waits for `done`. The result is then read in parallel. While `done` is high, the key bit is driven freely with no effect.

Top module: `serial_feistel_core`

## Requirements
- R1: After reset, `done` is 0 and `blk_out` is all zeros.
- R2: A cycle with `en` and `start` both high loads `blk_in` into the state, with bits 127:64 as the left word and bits 63:0 as the right word. It also latches `rounds`. When `rounds` is nonzero, `done` is 0 on the next cycle.
- R3: A round takes exactly 64 enabled cycles. `done` rises after the enabled edge that ends round number `rounds`, and not on any earlier edge.
- R4: After the run, `blk_out` equals the word-level round function applied `rounds` times, with left in bits 127:64 and right in bits 63:0.
- R5: After each round, the right word equals the left word from before that round. Bit by bit, the right chain takes in the old left bits.
- R6: Bit j of a round's key is sampled on the j-th enabled cycle of that round, counting from 0 (LSB first).
- R7: While `en` is low, nothing changes: state, counters, `done` and `blk_out` all hold.
- R8: A start with `rounds` equal to 0 raises `done` on the next cycle and leaves `blk_out` equal to `blk_in`.
- R9: Once `done` is high, it and `blk_out` hold until the next enabled start, whatever `key_bit` does.
- R10: A start during a run abandons that run and begins a new one from the new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Clock enable for the whole block |
| start | input | 1 | Load block and round count, begin a run |
| blk_in | input | 128 | Block to load, left word in the upper half |
| key_bit | input | 1 | Serial round-key bit, LSB first |
| rounds | input | 8 | Number of rounds to run |
| done | output | 1 | Run finished, result valid |
| blk_out | output | 128 | Current state, left word in the upper half |

## Verification
The assertions check the following on every cycle:
- the freeze under a low enable;
- the right chain capturing the left chain's output;
- `done` staying high until a new start;
- the counters being idle whenever no run is active.

Some behaviours only the bench's scenarios can show:
- that the computed words match the round function;
- that the key is taken LSB first;
- the exact cycle on which `done` rises;
- the zero-round case;
- restarting during a run;
- a stall in the middle of a round.

These are all checked against a word-level model of the cipher, fed the same key stream.

// File: rtl/serial_feistel_core.sv
module serial_feistel_core #(
  parameter int WORD = 64,
  parameter int WIN  = 8,
  parameter int RW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic [2*WORD-1:0] blk_in,
  input  logic              key_bit,
  input  logic [RW-1:0]     rounds,
  output logic              done,
  output logic [2*WORD-1:0] blk_out
);
  localparam int FL = WORD - WIN;
  localparam int CW = $clog2(WORD);
  localparam logic [CW-1:0] WIN_C  = CW'(WIN);
  localparam logic [CW-1:0] LAST_C = CW'(WORD - 1);

  logic [WIN-1:0]  win_up, win_dn;
  logic [FL-1:0]   lchain;
  logic [WORD-1:0] rchain;
  logic            up_old, busy;
  logic [CW-1:0]   bit_cnt;
  logic [RW-1:0]   rnd_cnt, rnd_lim;

  wire [WIN-1:0] old_w = up_old ? win_up : win_dn;
  wire [WIN-1:0] new_w = up_old ? win_dn : win_up;
  wire fbit = rchain[0] ^ old_w[WIN-2] ^ (old_w[WIN-1] & old_w[0]) ^ key_bit;
  wire head = (bit_cnt < WIN_C) ? old_w[0] : new_w[0];
  wire last_rnd = (rnd_cnt + RW'(1)) == rnd_lim;

  assign blk_out = {old_w, lchain, rchain};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_up  <= '0;
      win_dn  <= '0;
      lchain  <= '0;
      rchain  <= '0;
      up_old  <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
      bit_cnt <= '0;
      rnd_cnt <= '0;
      rnd_lim <= '0;
    end else if (en) begin
      if (start) begin
        win_up  <= blk_in[2*WORD-1 -: WIN];
        lchain  <= blk_in[WORD+FL-1:WORD];
        rchain  <= blk_in[WORD-1:0];
        up_old  <= 1'b1;
        bit_cnt <= '0;
        rnd_cnt <= '0;
        rnd_lim <= rounds;
        busy    <= rounds != '0;
        done    <= rounds == '0;
      end else if (busy) begin
        if (up_old) begin
          win_up <= {lchain[0], win_up[WIN-1:1]};
          win_dn <= {fbit, win_dn[WIN-1:1]};
        end else begin
          win_dn <= {lchain[0], win_dn[WIN-1:1]};
          win_up <= {fbit, win_up[WIN-1:1]};
        end
        lchain  <= {head, lchain[FL-1:1]};
        rchain  <= {lchain[0], rchain[WORD-1:1]};
        bit_cnt <= bit_cnt + CW'(1);
        if (bit_cnt == LAST_C) begin
          up_old  <= ~up_old;
          rnd_cnt <= rnd_cnt + RW'(1);
          if (last_rnd) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  AST_EN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(blk_out) && $stable(done) && $stable(bit_cnt) && $stable(rnd_cnt))); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && bit_cnt == '0)); // R3
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(en && start)) |=> (done && $stable(blk_out))); // R9
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start && rounds != '0) |=> (busy && !done)); // R2
  AST_ZERO_ROUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start && rounds == '0) |=> (done && blk_out == $past(blk_in))); // R8
  AST_RIGHT_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    (en && busy && !start) |=> (rchain[WORD-1] == $past(lchain[0]))); // R5
endmodule

// File: tb/tb_serial_feistel_core.sv
module tb_serial_feistel_core;
  logic clk = 0, rst_n = 0, en = 0, start = 0, key_bit = 0;
  logic [127:0] blk_in = '0;
  logic [7:0] rounds = '0;
  logic done;
  logic [127:0] blk_out;
  int total = 0, bad = 0;

  serial_feistel_core dut (.clk(clk), .rst_n(rst_n), .en(en), .start(start),
    .blk_in(blk_in), .key_bit(key_bit), .rounds(rounds), .done(done), .blk_out(blk_out));

  always #10 clk = ~clk;

  localparam int NV = 5;
  localparam logic [127:0] VBLK [NV] = '{
    128'h0123456789abcdef_fedcba9876543210,
    128'hffffffffffffffff_0000000000000000,
    128'h0000000000000001_8000000000000000,
    128'hdeadbeefcafef00d_1122334455667788,
    128'h63736564207372ee_6c6c65762065683b};
  localparam int VRND [NV] = '{1, 2, 3, 7, 68};
  localparam logic [63:0] VSEED [NV] = '{64'h0, 64'h0f0e0d0c0b0a0908,
    64'haaaa5555aaaa5555, 64'h1, 64'h0706050403020100};

  function automatic logic [63:0] rl(input logic [63:0] x, input int s);
    return (x << s) | (x >> (64 - s));
  endfunction
  function automatic logic [63:0] kw(input logic [63:0] seed, input int i);
    return seed ^ (64'(i) * 64'h9e3779b97f4a7c15);
  endfunction
  function automatic logic [127:0] model(input logic [127:0] b, input int n, input logic [63:0] seed);
    logic [63:0] l = b[127:64], r = b[63:0], t;
    for (int i = 0; i < n; i++) begin
      t = l;
      l = r ^ rl(l, 2) ^ (rl(l, 1) & rl(l, 8)) ^ kw(seed, i);
      r = t;
    end
    return {l, r};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [127:0] b, input int n);
    @(negedge clk);
    en = 1; start = 1; blk_in = b; rounds = 8'(n);
  endtask

  task automatic run(input int n, input logic [63:0] seed, input int stall_j);
    logic [127:0] snap;
    logic [63:0] k;
    for (int i = 0; i < n; i++) begin
      k = kw(seed, i);
      for (int j = 0; j < 64; j++) begin
        @(negedge clk);
        start = 0;
        key_bit = k[j];
        if (i == 0 && j == stall_j) begin
          en = 0; snap = blk_out;
          for (int s = 0; s < 10; s++) begin
            @(negedge clk);
            key_bit = ~key_bit;
            chk(blk_out == snap && !done, "R7 stall", blk_out, snap);
          end
          en = 1; key_bit = k[j];
        end
        if (i == n - 1 && j == 63) chk(!done, "R3 early done", 128'(done), 128'd0);
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] e, snap;
    repeat (3) @(negedge clk);
    chk(!done, "R1 done", 128'(done), 128'd0);
    chk(blk_out == '0, "R1 blk_out", blk_out, '0);
    rst_n = 1;

    for (int v = 0; v < NV; v++) begin
      do_start(VBLK[v], VRND[v]);
      run(VRND[v], VSEED[v], (v == 3) ? 37 : -1);
      e = model(VBLK[v], VRND[v], VSEED[v]);
      chk(done, "R3 done after run", 128'(done), 128'd1);
      chk(blk_out == e, "R4 R6 result", blk_out, e);
      if (VRND[v] == 1)
        chk(blk_out[63:0] == VBLK[v][127:64], "R5 right is old left", blk_out[63:0], VBLK[v][127:64]);
    end

    do_start('0, 1);
    run(1, 64'h20, -1);
    chk(blk_out == {64'h20, 64'h0}, "R6 key bit 5", blk_out, {64'h20, 64'h0});

    snap = blk_out;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      key_bit = c[0];
      chk(done && blk_out == snap, "R9 idle hold", blk_out, snap);
    end

    do_start(VBLK[3], 0);
    @(negedge clk);
    start = 0;
    chk(done, "R8 zero done", 128'(done), 128'd1);
    chk(blk_out == VBLK[3], "R8 zero passthrough", blk_out, VBLK[3]);

    do_start(VBLK[0], 3);
    @(negedge clk);
    start = 0;
    chk(!done, "R2 done cleared", 128'(done), 128'd0);
    for (int c = 0; c < 69; c++) begin
      @(negedge clk);
      key_bit = c[1];
    end
    do_start(VBLK[4], 2);
    run(2, VSEED[2], -1);
    e = model(VBLK[4], 2, VSEED[2]);
    chk(blk_out == e, "R10 restart", blk_out, e);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule